// File: doc/BRIEF.md
# Time-multiplexed NOR2 netlist evaluator

This block runs an acyclic circuit built only from two-input NOR gates, described by a gate list held in a small program memory. Each gate has a fixed number. Each entry of the list gives the two sources that feed that gate. A source is either a primary input bit or the result of a lower-numbered gate. The list must be in topological order, so a single forward pass over the gates is correct.

A start strobe captures the primary input vector. The evaluator then processes the gates two per cycle: gates 2k and 2k+1 are computed in step k. Each result is written into a value store indexed by gate number. When the odd gate of a pair reads the even gate of the same pair, that result is forwarded within the cycle. The outputs are the highest-numbered gates of the list. A done pulse marks the end of the pass. The gate list is written through a load port, which is accepted only while the evaluator is idle.

Top module: `nor2_eval`

## Requirements
- R1: After reset, busy_o and done_o are 0 and out_o is all zeros.
- R2: When done_o pulses, each gate holds the NOR of its two sources. out_o bit j equals the value of gate N_GATES-N_OUT+j.
- R3: A source field is 7 bits wide. If bit 6 is 1, bits 5:0 select a gate number. If bit 6 is 0, bits 3:0 select a primary input bit.
- R4: An odd gate 2k+1 that reads gate 2k uses the value gate 2k takes in the current run, never the value left from an earlier run.
- R5: done_o is a single-cycle pulse with busy_o low. It comes exactly N_GATES/2 cycles after the cycle in which start_i is accepted, and busy_o is high for all of those cycles.
- R6: A start_i that arrives while busy_o is high is ignored. It does not restart or extend the run and produces no extra done pulse.
- R7: A load write that arrives while busy_o is high is ignored. The stored gate list is unchanged.
- R8: While idle with no start, out_o holds its value, including when in_vec_i changes.
- R9: in_vec_i is sampled only in the cycle start_i is accepted. Changes during a run have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_we_i | input | 1 | Gate list write strobe (taken only when idle) |
| load_addr_i | input | 6 | Gate number to write |
| load_src_a_i | input | 7 | First source of the gate |
| load_src_b_i | input | 7 | Second source of the gate |
| start_i | input | 1 | Start evaluation (taken only when idle) |
| in_vec_i | input | 16 | Primary input vector |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| out_o | output | 8 | Values of the highest-numbered gates |

## Verification
The test netlist makes the eight outputs AND, NAND, NOR, OR and mixed functions of primary inputs through inverter gates. Some of these, among them the NAND and OR outputs, come from odd gates that read their even partner. Input vectors of all zeros, all ones and single-group patterns separate the gate functions from one another. The vectors are ordered so that a stale even-gate value would flip an odd-gate output, which shows the forwarding at work.

Directed runs cover four further cases:
- a start and a load issued mid-run, to show both are ignored;
- an input change mid-run, to show the inputs were captured at start;
- an idle period with changing inputs, to show the outputs hold;
- an idle reload of a gate to primary-input sources, to exercise that encoding.

// File: rtl/nor2_pkg.sv
package nor2_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} state_e;
endpackage

// File: rtl/nor2_prog_mem.sv
module nor2_prog_mem #(
  parameter int N_GATES = 64,
  parameter int SRC_W   = 7,
  localparam int IDX_W  = $clog2(N_GATES),
  localparam int PAIR_W = $clog2(N_GATES / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [SRC_W-1:0]  wsrc_a_i,
  input  logic [SRC_W-1:0]  wsrc_b_i,
  input  logic [PAIR_W-1:0] pair_i,
  output logic [SRC_W-1:0]  src_a_o [2],
  output logic [SRC_W-1:0]  src_b_o [2]
);
  logic [SRC_W-1:0] a_q [N_GATES];
  logic [SRC_W-1:0] b_q [N_GATES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < N_GATES; g++) begin
        a_q[g] <= '0;
        b_q[g] <= '0;
      end
    end else if (we_i) begin
      a_q[waddr_i] <= wsrc_a_i;
      b_q[waddr_i] <= wsrc_b_i;
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_rd
    assign src_a_o[l] = a_q[{pair_i, 1'(l)}];
    assign src_b_o[l] = b_q[{pair_i, 1'(l)}];
  end
endmodule

// File: rtl/nor2_lane.sv
module nor2_lane #(
  parameter int N_GATES = 64,
  parameter int N_IN    = 16,
  localparam int IDX_W  = $clog2(N_GATES),
  localparam int IN_W   = $clog2(N_IN),
  localparam int SRC_W  = IDX_W + 1
) (
  input  logic [SRC_W-1:0]   src_a_i,
  input  logic [SRC_W-1:0]   src_b_i,
  input  logic [N_IN-1:0]    in_vec_i,
  input  logic [N_GATES-1:0] vals_i,
  input  logic               fwd_en_i,
  input  logic [IDX_W-1:0]   fwd_idx_i,
  input  logic               fwd_val_i,
  output logic               res_o
);
  function automatic logic pick(input logic [SRC_W-1:0] s,
                                input logic [N_IN-1:0] iv,
                                input logic [N_GATES-1:0] v,
                                input logic fe,
                                input logic [IDX_W-1:0] fi,
                                input logic fv);
    logic [IDX_W-1:0] idx;
    idx = s[IDX_W-1:0];
    if (s[SRC_W-1]) begin
      // same-pair partner: take this cycle's result, not the stored one
      if (fe && idx == fi) return fv;
      return v[idx];
    end
    return iv[idx[IN_W-1:0]];
  endfunction

  logic a_val, b_val;
  assign a_val = pick(src_a_i, in_vec_i, vals_i, fwd_en_i, fwd_idx_i, fwd_val_i);
  assign b_val = pick(src_b_i, in_vec_i, vals_i, fwd_en_i, fwd_idx_i, fwd_val_i);
  assign res_o = ~(a_val | b_val);
endmodule

// File: rtl/nor2_value_store.sv
module nor2_value_store #(
  parameter int N_GATES = 64,
  localparam int PAIR_W = $clog2(N_GATES / 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PAIR_W-1:0]  pair_i,
  input  logic [1:0]         res_i,
  output logic [N_GATES-1:0] vals_o
);
  for (genvar g = 0; g < N_GATES; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        vals_o[g] <= 1'b0;
      else if (we_i && pair_i == PAIR_W'(g / 2))
        vals_o[g] <= res_i[g % 2];
    end
  end
endmodule

// File: rtl/nor2_eval.sv
module nor2_eval #(
  parameter int N_GATES = 64,
  parameter int N_IN    = 16,
  parameter int N_OUT   = 8,
  localparam int IDX_W  = $clog2(N_GATES),
  localparam int SRC_W  = IDX_W + 1,
  localparam int N_PAIRS = N_GATES / 2,
  localparam int PAIR_W = $clog2(N_PAIRS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_we_i,
  input  logic [IDX_W-1:0] load_addr_i,
  input  logic [SRC_W-1:0] load_src_a_i,
  input  logic [SRC_W-1:0] load_src_b_i,
  input  logic             start_i,
  input  logic [N_IN-1:0]  in_vec_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [N_OUT-1:0] out_o
);
  import nor2_pkg::*;

  state_e             state_q;
  logic [PAIR_W-1:0]  pair_q;
  logic [N_IN-1:0]    in_q;
  logic [N_GATES-1:0] vals;
  logic [SRC_W-1:0]   src_a [2];
  logic [SRC_W-1:0]   src_b [2];
  logic [1:0]         res;
  logic               run;

  assign run = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pair_q  <= '0;
      in_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          pair_q  <= '0;
          in_q    <= in_vec_i;
        end
        ST_RUN: begin
          pair_q <= pair_q + 1'b1;
          if (pair_q == PAIR_W'(N_PAIRS - 1)) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nor2_prog_mem #(.N_GATES(N_GATES), .SRC_W(SRC_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (load_we_i && !run),
    .waddr_i (load_addr_i),
    .wsrc_a_i(load_src_a_i),
    .wsrc_b_i(load_src_b_i),
    .pair_i  (pair_q),
    .src_a_o (src_a),
    .src_b_o (src_b)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    nor2_lane #(.N_GATES(N_GATES), .N_IN(N_IN)) u_lane (
      .src_a_i  (src_a[l]),
      .src_b_i  (src_b[l]),
      .in_vec_i (in_q),
      .vals_i   (vals),
      .fwd_en_i (l == 1),
      .fwd_idx_i({pair_q, 1'b0}),
      .fwd_val_i(res[0]),
      .res_o    (res[l])
    );
  end

  nor2_value_store #(.N_GATES(N_GATES)) u_vals (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (run),
    .pair_i(pair_q),
    .res_i (res),
    .vals_o(vals)
  );

  assign busy_o = run;
  assign out_o  = vals[N_GATES-1 -: N_OUT];
endmodule

// File: rtl/nor2_eval_chk.sv
module nor2_eval_chk #(
  parameter int N_GATES = 64,
  parameter int N_OUT   = 8,
  localparam int N_PAIRS = N_GATES / 2,
  localparam int CNT_W  = $clog2(N_PAIRS) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [N_OUT-1:0] out_o
);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r5_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_cnt == CNT_W'(N_PAIRS));
  a_r6_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r8_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(out_o));
endmodule

bind nor2_eval nor2_eval_chk #(.N_GATES(N_GATES), .N_OUT(N_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .out_o  (out_o)
);

// File: tb/tb_nor2_eval.sv
`timescale 1ns/1ps
module tb_nor2_eval;
  localparam int N_GATES = 64;
  localparam int N_IN = 16;
  localparam int N_OUT = 8;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       load_we_i = 0;
  logic [5:0] load_addr_i = '0;
  logic [6:0] load_src_a_i = '0, load_src_b_i = '0;
  logic       start_i = 0;
  logic [15:0] in_vec_i = '0;
  logic       busy_o, done_o;
  logic [7:0] out_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  nor2_eval dut (.*);

  // stimulus vector -> expected out_o for the test netlist
  localparam logic [23:0] VEC [6] = '{
    {16'h0000, 8'h16},
    {16'hFFFF, 8'h61},
    {16'h0003, 8'h15},
    {16'h0104, 8'h9A},  // after 0x0003: gate 56 goes 1->0, stale would clear bit 1
    {16'hC030, 8'h66},
    {16'h0158, 8'hA2}
  };

  function automatic logic [6:0] s_in(input int i);  return {1'b0, 6'(i)}; endfunction
  function automatic logic [6:0] s_g(input int g);   return {1'b1, 6'(g)}; endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input int g, input logic [6:0] a, input logic [6:0] b);
    load_we_i = 1; load_addr_i = 6'(g); load_src_a_i = a; load_src_b_i = b;
    @(negedge clk_i);
    load_we_i = 0;
  endtask

  // returns cycles from start acceptance to done visible
  task automatic run(input logic [15:0] v, output int cyc);
    in_vec_i = v; start_i = 1;
    @(negedge clk_i);
    start_i = 0; cyc = 0;
    while (!done_o && cyc < 1000) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int dones;
    logic [7:0] held;
    #35;
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 out", out_o, 0);
    @(negedge clk_i); rst_ni = 1; @(negedge clk_i);

    // R3 netlist: inverters on inputs, fillers, output logic at 56..63
    for (int g = 0; g < 16; g++) load(g, s_in(g), s_in(g));
    for (int g = 16; g < 56; g++) load(g, s_in(0), s_in(1));
    load(56, s_g(0), s_g(1));
    load(57, s_g(56), s_g(56));
    load(58, s_in(2), s_in(3));
    load(59, s_g(58), s_in(4));
    load(60, s_in(5), s_in(6));
    load(61, s_g(60), s_g(60));
    load(62, s_g(14), s_g(15));
    load(63, s_g(62), s_g(8));

    // R2 R3 R4 R5 table walk
    foreach (VEC[i]) begin
      run(VEC[i][23:8], cyc);
      chk("R2 out", out_o, VEC[i][7:0]);
      chk("R5 latency", cyc, N_GATES / 2);
      chk("R5 busy low at done", busy_o, 0);
      @(negedge clk_i);
      chk("R5 done one cycle", done_o, 0);
    end

    // R4 explicit: all ones then all zeros, NAND/OR outputs need fresh partner
    run(16'hFFFF, cyc);
    run(16'h0000, cyc);
    chk("R4 forwarded nand/or", out_o, 8'h16);

    // R6 R7 R9: mid-run start, load and input change
    in_vec_i = 16'h0104; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk("R5 busy after start", busy_o, 1);
    repeat (5) @(negedge clk_i);
    in_vec_i = 16'hFFFF;
    load(56, s_in(2), s_in(2));
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    cyc = 7;
    while (!done_o && cyc < 1000) begin @(negedge clk_i); cyc++; end
    chk("R9 inputs captured", out_o, 8'h9A);
    chk("R6 no restart", cyc, N_GATES / 2);
    dones = 0;
    repeat (40) begin @(negedge clk_i); if (done_o || busy_o) dones++; end
    chk("R6 no extra run", dones, 0);
    run(16'h0000, cyc);
    chk("R7 busy load ignored", out_o, 8'h16);

    // R8 idle hold
    held = out_o;
    for (int k = 0; k < 10; k++) begin
      in_vec_i = 16'(k * 16'h1357);
      @(negedge clk_i);
    end
    chk("R8 idle hold", out_o, held);

    // R3 idle reload to primary-input sources: gate56 = ~I2
    load(56, s_in(2), s_in(2));
    run(16'h0000, cyc);
    chk("R3 input source reload", out_o, 8'h15);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule